// File: doc/BRIEF.md
# End-of-Interrupt Scanner with Storm Throttling

This block takes an end-of-interrupt (EOI) vector number and walks the interrupt redirection table to release every level-triggered entry that was waiting on that vector. For each such entry it clears the remote-pending flag, which the table owner holds, with a one-cycle clear strobe. When the input line of a released entry is still asserted and the entry is unmasked, the block asks the delivery logic to run a service pass again. The vector comes from one of two sources: the processor-side broadcast, or a software write to an EOI register.

A level line that is asserted again at once after every EOI can hold the processor in a loop. To stop this, each pin has a counter of back-to-back redeliveries. When a pin's count reaches a limit, the block does not request service at once. It arms a one-shot delay timer, and the service request follows only when that timer expires. Any software write to a pin's table entry resets that pin's counter.

The table is read one pin per cycle through flattened per-pin inputs. While a scan is running, `busy` is high and new EOI strobes are ignored. Message generation is done elsewhere. This block only raises `service_req`.

Top module: `eoi_storm_throttle`

## Requirements
- R1: An entry is selected only when its 8-bit vector equals the EOI vector and its trigger-mode input is 1 (level). A selected entry whose remote-pending bit is 1 gets exactly one `rirr_clr` pulse on its bit. Edge entries (trigger mode 0) and entries with another vector get no pulse.
- R2: A selected entry whose remote-pending bit is already 0 gets no `rirr_clr` pulse, causes no `service_req`, and leaves its storm counter unchanged.
- R3: An accepted strobe starts a scan that visits pins 0 to NPINS-1 in ascending order, one pin per cycle. `busy` is high for exactly NPINS cycles, and any strobe that arrives while `busy` is high is ignored.
- R4: When a released entry is unmasked (mask input 0) and its `irr` bit is 1, its counter increments. If the new count is below STORM_LIMIT, `service_req` pulses high for one cycle in the cycle after that pin is visited. Otherwise, when the entry is masked or its `irr` bit is 0, the counter returns to zero and no request is made.
- R5: When an increment would reach STORM_LIMIT, the counter returns to zero and no immediate request is made. Instead the delay timer is armed, and `service_req` pulses exactly DELAY_CYCLES cycles after the arming edge.
- R6: Arming the timer while it is already running does not move its expiry. Two pins reaching the limit in one scan produce a single delayed request, timed from the first arming.
- R7: A pulse on `ent_wr_valid` resets the storm counter of the pin `ent_wr_pin` to zero.
- R8: `reg_eoi_valid` starts a scan only when the parameter VERSION equals 8'h20. Otherwise it is ignored. When both strobes arrive in the same cycle, the processor-side vector is used.
- R9: After reset, `busy`, `service_req` and `rirr_clr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_eoi_valid | input | 1 | Processor-side EOI strobe |
| cpu_eoi_vector | input | 8 | Processor-side EOI vector |
| reg_eoi_valid | input | 1 | EOI register write strobe |
| reg_eoi_vector | input | 8 | EOI register write data |
| ent_vector | input | NPINS*8 | Vector field of each entry, pin p at bits [8p+7:8p] |
| ent_level | input | NPINS | Trigger mode of each entry, 1 = level |
| ent_mask | input | NPINS | Mask bit of each entry, 1 = masked |
| ent_rirr | input | NPINS | Remote-pending bit of each entry |
| irr | input | NPINS | Current pending state of each input line |
| ent_wr_valid | input | 1 | Software wrote a table entry |
| ent_wr_pin | input | PIN_W | Pin index of that write |
| rirr_clr | output | NPINS | One-cycle clear strobe for remote-pending bits |
| service_req | output | 1 | One-cycle request for a delivery pass |
| busy | output | 1 | Table scan in progress |

## Verification
The tests use small limits: 8 pins, a storm limit of 4 and a 20-cycle delay. One vector is shared by a level entry, an edge entry and a level entry with another vector, which separates the vector check from the trigger-mode check. Entries whose remote-pending bit is already clear show that the "already released" case is skipped. Repeated EOIs with the line held high show three immediate requests and then one delayed request, sampled just before and just after the expected cycle. A table write, or an EOI with the line low, placed between the repeats shows that the counter resets. A strobe sent during a scan, a register EOI on a second instance built without register support, and two pins that reach the limit in the same scan cover the blocking, version and timer re-arm rules.

// File: rtl/eoi_throttle_pkg.sv
package eoi_throttle_pkg;
  // Version value for which the register EOI path is honoured
  localparam logic [7:0] EOI_REG_VERSION = 8'h20;

  // Fields of one table entry as seen by the scanner
  typedef struct packed {
    logic [7:0] vector;
    logic       level;
    logic       masked;
    logic       rirr;
  } ent_view_t;
endpackage

// File: rtl/eoi_scan_seq.sv
module eoi_scan_seq #(
  parameter int NPINS = 24,
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       start_vec,
  output logic             busy,
  output logic [PIN_W-1:0] idx,
  output logic [7:0]       vec
);
  localparam logic [PIN_W-1:0] LAST = PIN_W'(NPINS - 1);

  logic             busy_q, busy_d;
  logic [PIN_W-1:0] idx_q, idx_d;
  logic [7:0]       vec_q, vec_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    vec_d  = vec_q;
    if (busy_q) begin
      if (idx_q == LAST) busy_d = 1'b0;
      else               idx_d  = idx_q + 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      vec_d  = start_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
    end else if (busy_q || start) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      vec_q  <= vec_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign vec  = vec_q;
endmodule

// File: rtl/eoi_storm_cnt.sv
module eoi_storm_cnt #(
  parameter int NPINS       = 24,
  parameter int PIN_W       = 5,
  parameter int STORM_LIMIT = 10000,
  parameter int CNT_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [PIN_W-1:0] hit_pin,
  input  logic             bump,
  input  logic             wr_valid,
  input  logic [PIN_W-1:0] wr_pin,
  output logic             redeliver,
  output logic             arm
);
  localparam logic [CNT_W:0] LIM = (CNT_W+1)'(STORM_LIMIT);

  logic [CNT_W-1:0] cnt_q [NPINS];
  logic [CNT_W:0]   inc;
  logic             reached;

  assign inc       = {1'b0, cnt_q[hit_pin]} + 1'b1;
  assign reached   = (inc >= LIM);
  assign redeliver = hit && bump && !reached;
  assign arm       = hit && bump && reached;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [CNT_W-1:0] cnt_d;
    logic             wr_here, hit_here, cnt_en;

    assign wr_here  = wr_valid && (wr_pin == PIN_W'(p));
    assign hit_here = hit && (hit_pin == PIN_W'(p));
    assign cnt_en   = wr_here || hit_here;

    always_comb begin
      cnt_d = cnt_q[p];
      if (wr_here)                cnt_d = '0;
      else if (!bump || reached)  cnt_d = '0;
      else                        cnt_d = inc[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[p] <= '0;
      else if (cnt_en) cnt_q[p] <= cnt_d;
    end
  end
endmodule

// File: rtl/eoi_delay_timer.sv
module eoi_delay_timer #(
  parameter int DELAY_CYCLES = 2000000,
  parameter int TMR_W        = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic fire
);
  localparam logic [TMR_W-1:0] LOAD = TMR_W'(DELAY_CYCLES);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             running, tmr_en;

  assign running = (tmr_q != '0);
  assign tmr_en  = running || arm;
  assign fire    = (tmr_q == TMR_W'(1));

  // A running countdown is never reloaded: earliest expiry wins
  always_comb begin
    if (running) tmr_d = tmr_q - 1'b1;
    else         tmr_d = LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end
endmodule

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle
  import eoi_throttle_pkg::*;
#(
  parameter int          NPINS        = 24,
  parameter int          STORM_LIMIT  = 10000,
  parameter int          DELAY_CYCLES = 2000000,
  parameter logic [7:0]  VERSION      = 8'h20,
  parameter int          PIN_W        = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_eoi_valid,
  input  logic [7:0]         cpu_eoi_vector,
  input  logic               reg_eoi_valid,
  input  logic [7:0]         reg_eoi_vector,
  input  logic [NPINS*8-1:0] ent_vector,
  input  logic [NPINS-1:0]   ent_level,
  input  logic [NPINS-1:0]   ent_mask,
  input  logic [NPINS-1:0]   ent_rirr,
  input  logic [NPINS-1:0]   irr,
  input  logic               ent_wr_valid,
  input  logic [PIN_W-1:0]   ent_wr_pin,
  output logic [NPINS-1:0]   rirr_clr,
  output logic               service_req,
  output logic               busy
);
  localparam int  CNT_W   = $clog2(STORM_LIMIT + 1);
  localparam int  TMR_W   = $clog2(DELAY_CYCLES + 1);
  localparam bit  REG_EOI = (VERSION == EOI_REG_VERSION);

  logic             start;
  logic [7:0]       start_vec;
  logic [PIN_W-1:0] idx;
  logic [7:0]       scan_vec;
  ent_view_t        cur;
  logic             hit, bump, redeliver, arm, fire;
  logic             svc_q, svc_d;

  // Processor-side strobe has priority over the register path
  assign start     = cpu_eoi_valid || (REG_EOI && reg_eoi_valid);
  assign start_vec = cpu_eoi_valid ? cpu_eoi_vector : reg_eoi_vector;

  eoi_scan_seq #(.NPINS(NPINS), .PIN_W(PIN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_vec(start_vec),
    .busy(busy), .idx(idx), .vec(scan_vec)
  );

  always_comb begin
    cur.vector = ent_vector[8*idx +: 8];
    cur.level  = ent_level[idx];
    cur.masked = ent_mask[idx];
    cur.rirr   = ent_rirr[idx];
  end

  assign hit  = busy && cur.level && (cur.vector == scan_vec) && cur.rirr;
  assign bump = !cur.masked && irr[idx];

  always_comb begin
    rirr_clr = '0;
    rirr_clr[idx] = hit;
  end

  eoi_storm_cnt #(
    .NPINS(NPINS), .PIN_W(PIN_W), .STORM_LIMIT(STORM_LIMIT), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .hit(hit), .hit_pin(idx), .bump(bump),
    .wr_valid(ent_wr_valid), .wr_pin(ent_wr_pin),
    .redeliver(redeliver), .arm(arm)
  );

  eoi_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES), .TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .arm(arm), .fire(fire)
  );

  assign svc_d = redeliver || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= 1'b0;
    else        svc_q <= svc_d;
  end

  assign service_req = svc_q;
endmodule

// File: rtl/eoi_throttle_chk.sv
module eoi_throttle_chk #(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             cpu_eoi_valid,
  input logic             reg_eoi_valid,
  input logic [NPINS-1:0] ent_level,
  input logic [NPINS-1:0] ent_rirr,
  input logic [NPINS-1:0] rirr_clr
);
  // R1: at most one entry released per cycle
  p_one_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rirr_clr));

  // R1: edge entries are never released
  p_level_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_clr & ~ent_level) == '0);

  // R2: entries already released get no clear strobe
  p_set_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_clr & ~ent_rirr) == '0);

  // R3: clears only happen inside a scan
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rirr_clr == '0);

  // R8: register EOI alone cannot start a scan without register support
  p_reg_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (VERSION != 8'h20 && !busy && reg_eoi_valid && !cpu_eoi_valid) |=> !busy);
endmodule

bind eoi_storm_throttle eoi_throttle_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cpu_eoi_valid(cpu_eoi_valid),
  .reg_eoi_valid(reg_eoi_valid), .ent_level(ent_level), .ent_rirr(ent_rirr),
  .rirr_clr(rirr_clr)
);

// File: tb/test_eoi_storm_throttle.sv
`timescale 1ns/1ps
module test_eoi_storm_throttle;
  localparam int NP = 8;
  localparam int LIM = 4;
  localparam int DLY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cpu_v = 0, reg_v = 0, wr_v = 0;
  logic [7:0]    cpu_vec = 0, reg_vec = 0;
  logic [2:0]    wr_pin = 0;
  logic [7:0]    tvec [NP];
  logic [NP-1:0] tlvl = 0, tmsk = 0, trirr = 0, tirr = 0;
  logic [NP*8-1:0] vflat;
  logic [NP-1:0] clr, clr11;
  logic          svc, svc11, bsy, bsy11;

  always_comb for (int p = 0; p < NP; p++) vflat[8*p +: 8] = tvec[p];

  eoi_storm_throttle #(.NPINS(NP), .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY), .VERSION(8'h20))
  i_eoi_storm_throttle (
    .clk(clk), .rst_n(rst_n), .cpu_eoi_valid(cpu_v), .cpu_eoi_vector(cpu_vec),
    .reg_eoi_valid(reg_v), .reg_eoi_vector(reg_vec), .ent_vector(vflat),
    .ent_level(tlvl), .ent_mask(tmsk), .ent_rirr(trirr), .irr(tirr),
    .ent_wr_valid(wr_v), .ent_wr_pin(wr_pin), .rirr_clr(clr),
    .service_req(svc), .busy(bsy)
  );

  eoi_storm_throttle #(.NPINS(NP), .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY), .VERSION(8'h11))
  i_eoi_storm_throttle_v11 (
    .clk(clk), .rst_n(rst_n), .cpu_eoi_valid(1'b0), .cpu_eoi_vector(8'h00),
    .reg_eoi_valid(reg_v), .reg_eoi_vector(reg_vec), .ent_vector(vflat),
    .ent_level(tlvl), .ent_mask(tmsk), .ent_rirr(trirr), .irr(tirr),
    .ent_wr_valid(1'b0), .ent_wr_pin(3'd0), .rirr_clr(clr11),
    .service_req(svc11), .busy(bsy11)
  );

  int checks = 0, errors = 0;
  int svc_cnt = 0, busy_cyc = 0, v11_act = 0;
  int clr_cnt [NP];

  // Table model and observation counters
  always @(posedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++)
        if (clr[p]) begin trirr[p] <= 1'b0; clr_cnt[p] <= clr_cnt[p] + 1; end
      if (svc) svc_cnt <= svc_cnt + 1;
      if (bsy) busy_cyc <= busy_cyc + 1;
      if (bsy11 || svc11 || clr11 != 0) v11_act <= v11_act + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (bsy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); cpu_v = 1; cpu_vec = v;
    @(negedge clk); cpu_v = 0;
    while (bsy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_table();
    @(negedge clk);
    for (int p = 0; p < NP; p++) tvec[p] = 8'h00;
    tlvl = 0; tmsk = 0; trirr = 0; tirr = 0;
  endtask

  task automatic pin_write(input int p);
    @(negedge clk); wr_v = 1; wr_pin = 3'(p);
    @(negedge clk); wr_v = 0;
  endtask

  task automatic t_reset();
    chk("R9 busy", int'(bsy), 0);
    chk("R9 service_req", int'(svc), 0);
    chk("R9 rirr_clr", int'(clr), 0);
  endtask

  task automatic t_match();
    int c2, c3, c4, s0, b0;
    clear_table();
    tvec[2] = 8'h40; tlvl[2] = 1; trirr[2] = 1;
    tvec[3] = 8'h40; tlvl[3] = 0; trirr[3] = 1;
    tvec[4] = 8'h41; tlvl[4] = 1; trirr[4] = 1;
    c2 = clr_cnt[2]; c3 = clr_cnt[3]; c4 = clr_cnt[4]; s0 = svc_cnt; b0 = busy_cyc;
    eoi(8'h40);
    chk("R1 level match released", clr_cnt[2] - c2, 1);
    chk("R1 edge entry kept", int'(trirr[3]), 1);
    chk("R1 other vector kept", clr_cnt[4] - c4, 0);
    chk("R1 edge no pulse", clr_cnt[3] - c3, 0);
    chk("R4 line low no request", svc_cnt - s0, 0);
    chk("R3 busy length", busy_cyc - b0, NP);
  endtask

  task automatic t_already_clear();
    int c5, s0;
    clear_table();
    tvec[5] = 8'h33; tlvl[5] = 1; trirr[5] = 0; tirr[5] = 1;
    c5 = clr_cnt[5]; s0 = svc_cnt;
    eoi(8'h33);
    chk("R2 no clear pulse", clr_cnt[5] - c5, 0);
    chk("R2 no request", svc_cnt - s0, 0);
  endtask

  task automatic t_redeliver();
    int s0;
    clear_table();
    tvec[1] = 8'h50; tlvl[1] = 1; trirr[1] = 1; tirr[1] = 1;
    s0 = svc_cnt;
    eoi(8'h50);
    chk("R4 immediate request", svc_cnt - s0, 1);
    @(negedge clk); trirr[1] = 1; tmsk[1] = 1;
    s0 = svc_cnt;
    eoi(8'h50);
    chk("R4 masked no request", svc_cnt - s0, 0);
    pin_write(1);
  endtask

  task automatic storm_round(input int pin, input string tag);
    int s0;
    @(negedge clk); trirr[pin] = 1;
    s0 = svc_cnt;
    eoi(8'h60);
    chk(tag, svc_cnt - s0, 1);
  endtask

  task automatic t_storm();
    int s0;
    clear_table();
    tvec[1] = 8'h60; tlvl[1] = 1; tirr[1] = 1;
    pin_write(1);
    storm_round(1, "R5 round1 immediate");
    storm_round(1, "R5 round2 immediate");
    storm_round(1, "R5 round3 immediate");
    @(negedge clk); trirr[1] = 1;
    s0 = svc_cnt;
    eoi(8'h60);
    chk("R5 no immediate at limit", svc_cnt - s0, 0);
    repeat (12) @(negedge clk);
    chk("R5 not early", svc_cnt - s0, 0);
    repeat (2) @(negedge clk);
    chk("R5 delayed request", svc_cnt - s0, 1);
    storm_round(1, "R5 counter restarted");
  endtask

  task automatic t_write_clears();
    int s0;
    clear_table();
    tvec[1] = 8'h60; tlvl[1] = 1; tirr[1] = 1;
    pin_write(1);
    storm_round(1, "R7 prime1");
    storm_round(1, "R7 prime2");
    pin_write(1);
    storm_round(1, "R7 after write 1");
    storm_round(1, "R7 after write 2");
    storm_round(1, "R7 after write 3");
    // line low on a release resets the count (R4)
    @(negedge clk); trirr[1] = 1; tirr[1] = 0;
    s0 = svc_cnt; eoi(8'h60);
    chk("R4 low line no request", svc_cnt - s0, 0);
    @(negedge clk); tirr[1] = 1;
    storm_round(1, "R4 count reset 1");
    storm_round(1, "R4 count reset 2");
    storm_round(1, "R4 count reset 3");
    pin_write(1);
  endtask

  task automatic t_rearm();
    int s0;
    clear_table();
    tvec[1] = 8'h70; tlvl[1] = 1; tirr[1] = 1;
    tvec[6] = 8'h70; tlvl[6] = 1; tirr[6] = 1;
    pin_write(1); pin_write(6);
    for (int r = 0; r < LIM - 1; r++) begin
      @(negedge clk); trirr[1] = 1; trirr[6] = 1;
      s0 = svc_cnt; eoi(8'h70);
      chk("R6 priming two requests", svc_cnt - s0, 2);
    end
    @(negedge clk); trirr[1] = 1; trirr[6] = 1;
    s0 = svc_cnt;
    eoi(8'h70);
    repeat (12) @(negedge clk);
    chk("R6 not early", svc_cnt - s0, 0);
    repeat (2) @(negedge clk);
    chk("R6 first expiry kept", svc_cnt - s0, 1);
    repeat (10) @(negedge clk);
    chk("R6 single delayed request", svc_cnt - s0, 1);
  endtask

  task automatic t_busy_block();
    clear_table();
    tvec[2] = 8'h40; tlvl[2] = 1; trirr[2] = 1;
    tvec[5] = 8'h61; tlvl[5] = 1; trirr[5] = 1;
    @(negedge clk); cpu_v = 1; cpu_vec = 8'h40;
    @(negedge clk); cpu_vec = 8'h61;
    @(negedge clk); cpu_v = 0;
    wait_idle();
    chk("R3 strobe during scan ignored", int'(trirr[5]), 1);
    chk("R3 first scan released", int'(trirr[2]), 0);
  endtask

  task automatic t_reg_path();
    int a0;
    clear_table();
    tvec[3] = 8'h22; tlvl[3] = 1; trirr[3] = 1;
    tvec[4] = 8'h23; tlvl[4] = 1; trirr[4] = 1;
    a0 = v11_act;
    @(negedge clk); reg_v = 1; reg_vec = 8'h22;
    @(negedge clk); reg_v = 0;
    wait_idle();
    chk("R8 register EOI accepted", int'(trirr[3]), 0);
    chk("R8 other version ignores register EOI", v11_act - a0, 0);
    @(negedge clk); trirr[3] = 1;
    @(negedge clk); reg_v = 1; reg_vec = 8'h23; cpu_v = 1; cpu_vec = 8'h22;
    @(negedge clk); reg_v = 0; cpu_v = 0;
    wait_idle();
    chk("R8 processor vector wins", int'(trirr[3]), 0);
    chk("R8 register vector dropped", int'(trirr[4]), 1);
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin tvec[p] = 0; clr_cnt[p] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_match();
    t_already_clear();
    t_redeliver();
    t_storm();
    t_write_clears();
    t_rearm();
    t_busy_block();
    t_reg_path();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule